// File: doc/BRIEF.md
# Timed Event Code Sequencer

This block plays back a stored table of event codes, each paired with a time offset, onto an 8-bit event output. The output carries one value per event clock. A host port fills the table while the block is idle. The same port chooses the trigger source and selects single-shot or looping playback. The trigger source is either a software strobe or one of several external trigger lines, such as a divided counter output or a mains-phase pulse.

An accepted trigger clears a time counter to zero and starts walking the table from address 0. When the counter equals the time of the current entry, that entry's code is sent and the next entry becomes current. In every other cycle the output is the null code 0x00. An entry whose code is 0x7F ends the run, and so does the last table address. In looping mode the table then starts again from time zero at once. The table is read ahead by one entry, so entries due on consecutive cycles come out on consecutive cycles.

Top module: `evseq_player`

## Requirements
- R1: After reset `evt_code` is 0x00 and `busy` and `trig_busy_flag` are 0. `evt_code` is 0x00 in every cycle where no entry is due, including every cycle that follows an idle cycle.
- R2: A host write while idle stores `wr_code` and `wr_time` at `wr_addr`. A later run plays back that content.
- R3: `cfg_trig_sel` value 0 selects `sw_trig`. A value k from 1 to N_EXT selects `ext_trig[k-1]`. Any larger value selects nothing. A selected trigger that is high at a clock edge starts a run only if `cfg_enable` is 1 and `busy` is 0.
- R4: Entries are consumed in address order from 0, and their times must rise strictly. If the trigger is sampled at edge k, the code of an entry with time t is on `evt_code` for exactly the one cycle after edge k+t+1.
- R5: An entry with code 0x7F is emitted and ends the run. In single-shot mode `busy` falls at the same edge at which 0x7F appears.
- R6: If the entry at the last table address is not 0x7F, it ends the run in the same way.
- R7: A selected trigger that arrives while `busy` is 1 leaves playback unchanged and sets `trig_busy_flag`. The flag stays set until `flag_clr` is pulsed. If a set and a clear arrive in the same cycle, the set wins.
- R8: A host write made while `busy` is 1, or in the cycle in which a trigger is accepted, is discarded.
- R9: With `cfg_recycle` set, the cycle after the ending entry is time 0 of a new pass. The loop period is therefore the ending entry's time plus one.
- R10: Driving `cfg_enable` low ends any run at the next edge. From that edge `evt_code` is 0x00.
- R11: Entries whose times differ by one are emitted in back-to-back cycles, with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Sequencer enable |
| cfg_recycle | input | 1 | Loop the table continuously |
| cfg_trig_sel | input | SEL_W | Trigger source select |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | N_EXT | External trigger lines |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table write address |
| wr_code | input | 8 | Event code to store |
| wr_time | input | TIME_W | Time offset to store |
| flag_clr | input | 1 | Clears the trigger-while-busy flag |
| evt_code | output | 8 | Emitted event code, 0x00 when none is due |
| busy | output | 1 | A run is in progress |
| trig_busy_flag | output | 1 | Sticky flag: a trigger arrived during a run |

## Verification
The checks assume that triggers, writes and configuration are synchronous to the event clock. They also assume that the times in the table rise strictly up to the ending entry, because an entry whose time has already passed would stall playback until the counter wraps. The stimulus changes inputs only between clock edges. It gives every table a strictly rising time list, and it uses 0x7F only as the ending code. The bench checks every output cycle of each run against an expected code, which it computes from a shadow copy of the table it wrote, with time taken modulo the period in looping mode.

// File: rtl/evseq_pkg.sv
package evseq_pkg;
   localparam int unsigned EV_CODE_W = 8;
   localparam logic [EV_CODE_W-1:0] EV_NULL = 8'h00;
   localparam logic [EV_CODE_W-1:0] EV_STOP = 8'h7F;
endpackage

// File: rtl/evseq_trig_sel.sv
module evseq_trig_sel #(
   parameter int N_EXT = 4,
   parameter int SEL_W = 3
) (
   input  logic             sw_trig,
   input  logic [N_EXT-1:0] ext_trig,
   input  logic [SEL_W-1:0] sel,
   output logic             trig_o
);
   localparam int N_SRC = N_EXT + 1;

   logic [N_SRC-1:0] srcs;
   assign srcs = {ext_trig, sw_trig};

   always_comb begin
      trig_o = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (sel == SEL_W'(i)) trig_o = srcs[i];
      end
   end
endmodule

// File: rtl/evseq_table_ram.sv
module evseq_table_ram #(
   parameter int DEPTH = 2048,
   parameter int WIDTH = 40,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WIDTH-1:0]  rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/evseq_playback.sv
module evseq_playback
   import evseq_pkg::*;
#(
   parameter int DEPTH  = 2048,
   parameter int TIME_W = 32,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 recycle,
   input  logic                 trig,
   input  logic                 flag_clr,
   input  logic [EV_CODE_W-1:0] ent_code,
   input  logic [TIME_W-1:0]    ent_time,
   output logic [ADDR_W-1:0]    rd_addr,
   output logic                 start,
   output logic                 busy,
   output logic [EV_CODE_W-1:0] evt_code,
   output logic                 busy_flag
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] ptr;
   logic [TIME_W-1:0] tcnt;
   logic              hit;
   logic              last;

   assign hit   = busy && enable && (ent_time == tcnt);
   assign last  = (ent_code == EV_STOP) || (ptr == LAST_ADDR);
   assign start = !busy && enable && trig;

   // Read-ahead: on a hit the next entry is fetched so it is current next cycle
   always_comb begin
      if (!busy || !enable || (hit && last)) rd_addr = '0;
      else if (hit)                           rd_addr = ptr + 1'b1;
      else                                    rd_addr = ptr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         ptr      <= '0;
         tcnt     <= '0;
         evt_code <= EV_NULL;
      end else begin
         evt_code <= hit ? ent_code : EV_NULL;
         if (!enable) begin
            busy <= 1'b0;
            ptr  <= '0;
            tcnt <= '0;
         end else if (start) begin
            busy <= 1'b1;
            ptr  <= '0;
            tcnt <= '0;
         end else if (busy) begin
            if (hit && last) begin
               ptr  <= '0;
               tcnt <= '0;
               busy <= recycle;
            end else begin
               tcnt <= tcnt + 1'b1;
               if (hit) ptr <= ptr + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       busy_flag <= 1'b0;
      else if (busy && enable && trig)  busy_flag <= 1'b1;
      else if (flag_clr)                busy_flag <= 1'b0;
   end
endmodule

// File: rtl/evseq_player.sv
module evseq_player
   import evseq_pkg::*;
#(
   parameter int DEPTH  = 2048,
   parameter int TIME_W = 32,
   parameter int N_EXT  = 4,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int SEL_W  = $clog2(N_EXT + 1),
   localparam int ENT_W  = EV_CODE_W + TIME_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_enable,
   input  logic                 cfg_recycle,
   input  logic [SEL_W-1:0]     cfg_trig_sel,
   input  logic                 sw_trig,
   input  logic [N_EXT-1:0]     ext_trig,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [EV_CODE_W-1:0] wr_code,
   input  logic [TIME_W-1:0]    wr_time,
   input  logic                 flag_clr,
   output logic [EV_CODE_W-1:0] evt_code,
   output logic                 busy,
   output logic                 trig_busy_flag
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("evseq_player: DEPTH must be at least 2");
   end
   if (TIME_W < 1 || TIME_W > 64) begin : g_bad_time
      $error("evseq_player: TIME_W must be 1..64");
   end
   if (N_EXT < 1) begin : g_bad_ext
      $error("evseq_player: N_EXT must be at least 1");
   end

   logic              trig_sel_pulse;
   logic              start;
   logic              wr_ok;
   logic [ADDR_W-1:0] rd_addr;
   logic [ENT_W-1:0]  ram_q;

   evseq_trig_sel #(.N_EXT(N_EXT), .SEL_W(SEL_W)) u_trig (
      .sw_trig (sw_trig),
      .ext_trig(ext_trig),
      .sel     (cfg_trig_sel),
      .trig_o  (trig_sel_pulse)
   );

   assign wr_ok = wr_en && !busy && !start;

   evseq_table_ram #(.DEPTH(DEPTH), .WIDTH(ENT_W)) u_ram (
      .clk  (clk),
      .we   (wr_ok),
      .waddr(wr_addr),
      .wdata({wr_code, wr_time}),
      .raddr(rd_addr),
      .rdata(ram_q)
   );

   evseq_playback #(.DEPTH(DEPTH), .TIME_W(TIME_W)) u_play (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (cfg_enable),
      .recycle  (cfg_recycle),
      .trig     (trig_sel_pulse),
      .flag_clr (flag_clr),
      .ent_code (ram_q[ENT_W-1 -: EV_CODE_W]),
      .ent_time (ram_q[TIME_W-1:0]),
      .rd_addr  (rd_addr),
      .start    (start),
      .busy     (busy),
      .evt_code (evt_code),
      .busy_flag(trig_busy_flag)
   );
endmodule

// File: rtl/evseq_player_chk.sv
module evseq_player_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_enable,
   input logic       cfg_recycle,
   input logic       flag_clr,
   input logic       trig_sel_pulse,
   input logic [7:0] evt_code,
   input logic       busy,
   input logic       trig_busy_flag
);
   a_r1_idle_null: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> evt_code == 8'h00);

   a_r3_start_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_enable && trig_sel_pulse) |=> busy);

   a_r5_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_code == 8'h7F && !$past(cfg_recycle)) |-> !busy);

   a_r7_busy_trigger_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_enable && trig_sel_pulse) |=> trig_busy_flag);

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_busy_flag && !flag_clr) |=> trig_busy_flag);

   a_r10_disable_aborts: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (!busy && evt_code == 8'h00));
endmodule

bind evseq_player evseq_player_chk u_chk (.*);

// File: tb/evseq_player_tb.sv
module evseq_player_tb_top;
   localparam int DEPTH  = 8;
   localparam int TIME_W = 12;
   localparam int N_EXT  = 2;
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int SEL_W  = $clog2(N_EXT + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_enable = 1'b0;
   logic              cfg_recycle = 1'b0;
   logic [SEL_W-1:0]  cfg_trig_sel = '0;
   logic              sw_trig = 1'b0;
   logic [N_EXT-1:0]  ext_trig = '0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [7:0]        wr_code = '0;
   logic [TIME_W-1:0] wr_time = '0;
   logic              flag_clr = 1'b0;
   logic [7:0]        evt_code;
   logic              busy;
   logic              trig_busy_flag;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int sc [DEPTH];
   int st [DEPTH];

   always #5 clk = ~clk;

   evseq_player #(.DEPTH(DEPTH), .TIME_W(TIME_W), .N_EXT(N_EXT)) dut_i (.*);

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic wr_entry(input int a, input int code, input int tm);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_code = 8'(code); wr_time = TIME_W'(tm);
      @(negedge clk);
      wr_en = 1'b0;
      sc[a] = code; st[a] = tm;
   endtask

   function automatic int last_idx();
      for (int i = 0; i < DEPTH; i++) if (sc[i] == 'h7F) return i;
      return DEPTH - 1;
   endfunction

   function automatic int exp_code(input int t, input bit rec);
      int l = last_idx();
      int tt = rec ? t % (st[l] + 1) : t;
      for (int i = 0; i <= l; i++) if (st[i] == tt) return sc[i];
      return 0;
   endfunction

   // act 1: software trigger while busy; act 2: host write while busy
   task automatic run_seq(input int sel, input int ncyc, input bit rec,
                          input int act_t, input int act);
      int lt = st[last_idx()];
      cfg_recycle = rec;
      cfg_trig_sel = SEL_W'(sel);
      if (sel == 0) sw_trig = 1'b1; else ext_trig[sel-1] = 1'b1;
      @(negedge clk);
      sw_trig = 1'b0; ext_trig = '0;
      for (int t = 0; t < ncyc; t++) begin
         @(negedge clk);
         chk(evt_code == 8'(exp_code(t, rec)), "R4/R5/R9/R11 code", evt_code, exp_code(t, rec));
         chk(busy == (rec ? 1'b1 : (t < lt)), "R5/R6/R9 busy", busy, rec ? 1 : int'(t < lt));
         if (t == act_t && act == 1) sw_trig = 1'b1;
         if (t == act_t && act == 2) begin
            wr_en = 1'b1; wr_addr = 1; wr_code = 8'hEE; wr_time = 1;
         end
         if (t == act_t + 1) begin sw_trig = 1'b0; wr_en = 1'b0; end
      end
      sw_trig = 1'b0; wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(evt_code == 0, "R1 reset code", evt_code, 0);
      chk(busy == 0, "R1 reset busy", busy, 0);
      chk(trig_busy_flag == 0, "R1 reset flag", trig_busy_flag, 0);

      // R2/R4/R5/R11: table with back-to-back times 3,4
      for (int i = 0; i < DEPTH; i++) begin sc[i] = 0; st[i] = 0; end
      wr_entry(0, 'h11, 0); wr_entry(1, 'h22, 3);
      wr_entry(2, 'h33, 4); wr_entry(3, 'h7F, 9);
      cfg_enable = 1'b1;
      run_seq(0, 14, 1'b0, -5, 0);
      chk(trig_busy_flag == 0, "R7 no spurious flag", trig_busy_flag, 0);

      // R7: trigger while busy ignored, flag sticky until cleared
      run_seq(0, 12, 1'b0, 1, 1);
      chk(trig_busy_flag == 1, "R7 flag set", trig_busy_flag, 1);
      repeat (3) @(negedge clk);
      chk(trig_busy_flag == 1, "R7 flag sticky", trig_busy_flag, 1);
      flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
      chk(trig_busy_flag == 0, "R7 flag cleared", trig_busy_flag, 0);

      // R8: write during run discarded, rerun shows old table
      run_seq(1, 12, 1'b0, 2, 2);
      run_seq(2, 12, 1'b0, -5, 0);

      // R8: write in the trigger acceptance cycle is discarded
      cfg_trig_sel = 0;
      sw_trig = 1'b1; wr_en = 1'b1; wr_addr = 0; wr_code = 8'hAB; wr_time = 0;
      @(negedge clk);
      sw_trig = 1'b0; wr_en = 1'b0;
      repeat (12) @(negedge clk);
      run_seq(0, 12, 1'b0, -5, 0);

      // R3: trigger select sweep, including an unused select value
      for (int sel = 0; sel < (1 << SEL_W); sel++) begin
         for (int src = 0; src <= N_EXT; src++) begin
            cfg_trig_sel = SEL_W'(sel);
            if (src == 0) sw_trig = 1'b1; else ext_trig[src-1] = 1'b1;
            @(negedge clk);
            sw_trig = 1'b0; ext_trig = '0;
            chk(busy == (sel == src), "R3 trigger select", busy, int'(sel == src));
            cfg_enable = 1'b0; @(negedge clk);
            chk(busy == 0 && evt_code == 0, "R10 abort", busy, 0);
            cfg_enable = 1'b1;
         end
      end

      // R3: trigger while disabled ignored
      cfg_enable = 1'b0; cfg_trig_sel = 0; sw_trig = 1'b1;
      @(negedge clk); sw_trig = 1'b0; @(negedge clk);
      chk(busy == 0 && trig_busy_flag == 0, "R3 disabled trigger", busy, 0);
      cfg_enable = 1'b1;

      // R9/R10: recycle, then disable
      wr_entry(0, 'h05, 0); wr_entry(1, 'h06, 2); wr_entry(2, 'h7F, 5);
      run_seq(0, 20, 1'b1, -5, 0);
      cfg_enable = 1'b0; @(negedge clk);
      chk(busy == 0, "R10 disable busy", busy, 0);
      chk(evt_code == 0, "R10 disable code", evt_code, 0);
      repeat (2) @(negedge clk);
      chk(evt_code == 0, "R1 idle null", evt_code, 0);
      cfg_enable = 1'b1;

      // R6: full table without end code, single shot then looping
      for (int i = 0; i < DEPTH; i++) wr_entry(i, 'h40 + i, 2 * i + 1);
      run_seq(0, 18, 1'b0, -5, 0);
      run_seq(0, 34, 1'b1, -5, 0);
      cfg_enable = 1'b0; @(negedge clk);
      chk(busy == 0, "R10 disable loop", busy, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected <= 50000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule